// File: doc/BRIEF.md
# Level-Prioritized Interrupt Controller

This block gathers a parameterized set of interrupt sources (up to 32) into a pending register and reports to the core the most urgent priority level that can interrupt it. External pins are routed to internal interrupt numbers through an elaboration-time routing table. Each internal interrupt is either level-type, where the pending bit follows the synchronized input, or edge-type, where a rising edge latches the bit until software clears it.

Priority is not decided by bit index. Each priority level owns a group mask of interrupt bits. The controller takes the active set, which is the pending bits ANDed with the enable bits. It then walks the levels from the top down, considering only levels strictly above the core's current level. The first level whose group intersects the active set is reported as a level code, together with a request line. Both outputs come from registers.

Software reaches the block through three write ports. One loads the enable register, one loads the current level, and one clears latched edge bits by writing ones.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, the pending register, the enable register and the current level are zero, and both `irq_req_o` and `irq_level_o` are 0.
- R2: External pin p drives internal interrupt `EXT_MAP[5p+4:5p]`. A pin whose entry is N_IRQ or above reaches no interrupt and never changes `pending_o`. The defaults route pins 0..7 to interrupts 0..7 and pin 8 to 20.
- R3: A level-type interrupt's pending bit is set 3 clock edges after its pin rises and is cleared 3 edges after it falls. The delay comes from two synchronizer stages plus the pending register. The default `EDGE_TYPE` is 8'hAA, so bits 0, 2, 4 and 6 are level-type.
- R4: An edge-type pending bit is set 3 edges after a 0-to-1 pin transition. It stays set after the pin falls.
- R5: A write with `clr_we` clears, at the next edge, each edge-type pending bit written as 1. Bits written 0 and level-type bits are unaffected. If a new rising edge arrives in the same cycle as the clear, the bit stays set.
- R6: Only bits that are both pending and enabled take part in the level decision. A pending bit whose enable is 0 never raises a request.
- R7: `irq_level_o` is the highest level k whose group mask intersects the active set and for which k is greater than the current level.
- R8: When no level qualifies, `irq_level_o` is 0 and `irq_req_o` is 0. Otherwise `irq_req_o` is 1.
- R9: `irq_req_o` and `irq_level_o` change exactly one clock edge after the pending, enable or current-level state changes.
- R10: Level k's group is `LVL_MASK[k*N_IRQ-1:(k-1)*N_IRQ]`. The defaults place interrupts 0-2 at level 1, 3-5 at level 2 and 6-7 at level 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_irq_i | input | N_EXT | Asynchronous external interrupt pins |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | N_IRQ | New enable mask |
| lvl_we | input | 1 | Current-level write strobe |
| lvl_wdata | input | LW | New current interrupt level |
| clr_we | input | 1 | Write-one-to-clear strobe for edge bits |
| clr_wdata | input | N_IRQ | Bits to clear |
| pending_o | output | N_IRQ | Pending register |
| irq_level_o | output | LW | Registered pending level code, 0 for none |
| irq_req_o | output | 1 | Registered interrupt request to the core |

## Verification
The bench sweeps all 256 pending patterns of the default configuration. For each pattern it tries every current level and eight enable masks, and compares the result against a model that computes each bit's level arithmetically. A resolver that used bit index order, compared the current level with greater-or-equal, or ignored the enable register would report the wrong level or raise a request at the threshold. Directed cases cover the unrouted pin, which a decoder with a truncated index would fold onto a real bit, and edge bits that must survive their pin falling. They also cover a clear that must leave level bits alone, and a clear that arrives together with a fresh edge, which a clear-priority design would drop. Checks one edge apart catch an output register that is missing or doubled.

// File: rtl/lvl_irq_pkg.sv
// Package: shared limits for the level-prioritized interrupt controller.
// Assumes no configuration exceeds 32 interrupts or 7 levels.
package lvl_irq_pkg;
    localparam int MAX_IRQ = 32;
    localparam int MAX_LVL = 7;
    localparam int MAP_W   = 5;   // width of one pin routing entry

    // Number of bits needed to code levels 0..n_lvl.
    function automatic int lvl_width(input int n_lvl);
        return (n_lvl < 2) ? 1 : $clog2(n_lvl + 1);
    endfunction
endpackage

// File: rtl/lvl_irq_sync.sv
// Module: two-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is an independent slow level; no bus coherency is implied.
module lvl_irq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Capture the raw inputs, then resample once to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/lvl_irq_pending.sv
// Module: pending register with per-bit latching rules.
// Level-type bits follow the synchronized input. Edge-type bits set on a
// rising edge and clear only through write-one-to-clear; a new edge beats a clear.
module lvl_irq_pending #(
    parameter int               N_IRQ     = 8,
    parameter logic [N_IRQ-1:0] EDGE_TYPE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] sync_i,
    input  logic             clr_we,
    input  logic [N_IRQ-1:0] clr_wdata,
    output logic [N_IRQ-1:0] pend_o
);
    logic [N_IRQ-1:0] prev_q;
    logic [N_IRQ-1:0] pend_q;
    logic [N_IRQ-1:0] rise;
    logic [N_IRQ-1:0] clr_hit;
    logic [N_IRQ-1:0] pend_d;

    assign rise    = sync_i & ~prev_q;
    assign clr_hit = clr_we ? clr_wdata : '0;

    // Next pending value per bit, chosen by its configured type.
    always_comb begin
        for (int i = 0; i < N_IRQ; i++) begin
            if (EDGE_TYPE[i]) pend_d[i] = rise[i] | (pend_q[i] & ~clr_hit[i]);
            else              pend_d[i] = sync_i[i];
        end
    end

    // Hold the previous synchronized value and the pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= sync_i;
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;

    // Per-bit checks for the edge-type latching rules.
    for (genvar g = 0; g < N_IRQ; g++) begin : g_chk
        if (EDGE_TYPE[g]) begin : g_edge
            AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
                rise[g] |=> pend_q[g]);                                   // R4
            AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_q[g] && !clr_hit[g]) |=> pend_q[g]);                // R4
            AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_hit[g] && !rise[g]) |=> !pend_q[g]);                 // R5
        end
    end
endmodule

// File: rtl/lvl_irq_resolve.sv
// Module: level resolver. Masks pending with enable, scans levels from the top
// down above the current level, and registers the winning level and request.
// Assumes LVL_MASK holds N_LVL groups of N_IRQ bits, level 1 in the low slice.
module lvl_irq_resolve #(
    parameter int                     N_IRQ    = 8,
    parameter int                     N_LVL    = 3,
    parameter int                     LW       = 2,
    parameter logic [N_LVL*N_IRQ-1:0] LVL_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] pend_i,
    input  logic [N_IRQ-1:0] en_i,
    input  logic [LW-1:0]    cur_i,
    output logic [LW-1:0]    lvl_o,
    output logic             req_o
);
    logic [N_IRQ-1:0] active;
    logic [LW-1:0]    best;
    logic             found;
    logic [LW-1:0]    lvl_q;
    logic             req_q;

    assign active = pend_i & en_i;

    // Walk levels top down; the first eligible level with an active member wins.
    always_comb begin
        best  = '0;
        found = 1'b0;
        for (int k = N_LVL; k >= 1; k--) begin
            if (!found && (LW'(k) > cur_i) &&
                (|(active & LVL_MASK[(k-1)*N_IRQ +: N_IRQ]))) begin
                best  = LW'(k);
                found = 1'b1;
            end
        end
    end

    // Register the decision so outputs change one edge after any input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
            req_q <= 1'b0;
        end else begin
            lvl_q <= best;
            req_q <= found;
        end
    end

    assign lvl_o = lvl_q;
    assign req_o = req_q;

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !req_q |-> (lvl_q == '0));                                        // R8
    AST_ABOVE_CUR: assert property (@(posedge clk) disable iff (!rst_n)
        found |=> (lvl_q > $past(cur_i)));                                // R7
    AST_NONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |=> !req_q);                                       // R6
endmodule

// File: rtl/lvl_irq_ctrl.sv
// Module: top of the level-prioritized interrupt controller. Routes pins to
// interrupt numbers, synchronizes them, keeps the enable and current-level
// registers, and feeds the pending and resolver stages.
// Assumes N_IRQ <= 32 and N_LVL <= 7; routing entries at N_IRQ or above are unused.
module lvl_irq_ctrl
    import lvl_irq_pkg::*;
#(
    parameter int                        N_IRQ     = 8,
    parameter int                        N_LVL     = 3,
    parameter int                        N_EXT     = 9,
    parameter logic [N_EXT*MAP_W-1:0]    EXT_MAP   = {5'd20, 5'd7, 5'd6, 5'd5, 5'd4,
                                                      5'd3, 5'd2, 5'd1, 5'd0},
    parameter logic [N_IRQ-1:0]          EDGE_TYPE = 8'hAA,
    parameter logic [N_LVL*N_IRQ-1:0]    LVL_MASK  = 24'hC0_38_07,
    localparam int                       LW        = lvl_width(N_LVL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] ext_irq_i,
    input  logic             en_we,
    input  logic [N_IRQ-1:0] en_wdata,
    input  logic             lvl_we,
    input  logic [LW-1:0]    lvl_wdata,
    input  logic             clr_we,
    input  logic [N_IRQ-1:0] clr_wdata,
    output logic [N_IRQ-1:0] pending_o,
    output logic [LW-1:0]    irq_level_o,
    output logic             irq_req_o
);
    logic [N_IRQ-1:0] routed;
    logic [N_IRQ-1:0] synced;
    logic [N_IRQ-1:0] pend;
    logic [N_IRQ-1:0] en_q;
    logic [LW-1:0]    cur_q;

    // Fold each pin onto the interrupt its routing entry names; others drop out.
    always_comb begin
        routed = '0;
        for (int i = 0; i < N_IRQ; i++) begin
            for (int p = 0; p < N_EXT; p++) begin
                if (EXT_MAP[p*MAP_W +: MAP_W] == MAP_W'(i)) routed[i] = routed[i] | ext_irq_i[p];
            end
        end
    end

    // Software-written enable mask and current interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            cur_q <= '0;
        end else begin
            if (en_we)  en_q  <= en_wdata;
            if (lvl_we) cur_q <= lvl_wdata;
        end
    end

    lvl_irq_sync #(.W(N_IRQ)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (routed),
        .sync_o  (synced)
    );

    lvl_irq_pending #(.N_IRQ(N_IRQ), .EDGE_TYPE(EDGE_TYPE)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_i    (synced),
        .clr_we    (clr_we),
        .clr_wdata (clr_wdata),
        .pend_o    (pend)
    );

    lvl_irq_resolve #(.N_IRQ(N_IRQ), .N_LVL(N_LVL), .LW(LW), .LVL_MASK(LVL_MASK)) u_res (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend),
        .en_i   (en_q),
        .cur_i  (cur_q),
        .lvl_o  (irq_level_o),
        .req_o  (irq_req_o)
    );

    assign pending_o = pend;

    AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & en_q) == '0) |=> !irq_req_o);                            // R6
    AST_LEVEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lvl_we) |-> (cur_q == $past(lvl_wdata)));                   // R9
endmodule

// File: tb/lvl_irq_ctrl_bench.sv
// Bench: directed corner cases plus a sweep over every pending pattern,
// every current level and eight enable masks of the default configuration.
module lvl_irq_ctrl_bench;
    localparam int N_IRQ = 8;
    localparam int N_EXT = 9;
    localparam logic [7:0] EDGE = 8'hAA;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_EXT-1:0] ext_irq_i = '0;
    logic             en_we = 1'b0;
    logic [N_IRQ-1:0] en_wdata = '0;
    logic             lvl_we = 1'b0;
    logic [1:0]       lvl_wdata = '0;
    logic             clr_we = 1'b0;
    logic [N_IRQ-1:0] clr_wdata = '0;
    logic [N_IRQ-1:0] pending_o;
    logic [1:0]       irq_level_o;
    logic             irq_req_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    lvl_irq_ctrl u_lvl_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_irq_i),
        .en_we(en_we), .en_wdata(en_wdata),
        .lvl_we(lvl_we), .lvl_wdata(lvl_wdata),
        .clr_we(clr_we), .clr_wdata(clr_wdata),
        .pending_o(pending_o), .irq_level_o(irq_level_o), .irq_req_o(irq_req_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Wait n rising edges, then move to the following falling edge.
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Level of interrupt i under the default groups: 0-2 ->1, 3-5 ->2, 6-7 ->3.
    function automatic int lvl_of(input int i);
        return (i / 3 + 1 > 3) ? 3 : i / 3 + 1;
    endfunction

    function automatic int model(input int p, input int e, input int cur);
        int best = 0;
        for (int i = 0; i < N_IRQ; i++)
            if (((p & e) >> i) & 1)
                if (lvl_of(i) > cur && lvl_of(i) > best) best = lvl_of(i);
        return best;
    endfunction

    task automatic write_regs(input int e, input int cur);
        en_we = 1'b1; en_wdata = 8'(e); lvl_we = 1'b1; lvl_wdata = 2'(cur);
        tick(1);
        en_we = 1'b0; lvl_we = 1'b0;
    endtask

    task automatic load_pending(input int p);
        ext_irq_i = '0; clr_we = 1'b1; clr_wdata = 8'hFF;
        tick(1);
        clr_we = 1'b0; clr_wdata = '0;
        ext_irq_i = {1'b0, 8'(p)};
        tick(4);
        ext_irq_i = {1'b0, 8'(p) & ~EDGE};
        tick(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int ev[8];
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R1 pending", int'(pending_o), 0);
        check("R1 req", int'(irq_req_o), 0);
        check("R1 level", int'(irq_level_o), 0);

        // R1: enable starts at zero, so a pending level bit raises nothing.
        ext_irq_i[0] = 1'b1;
        tick(5);
        check("R1 enable reset", int'(irq_req_o), 0);
        ext_irq_i[0] = 1'b0;
        tick(4);

        write_regs(8'hFF, 0);
        // R2: pin 8 routes to 20, beyond the configured count.
        ext_irq_i[8] = 1'b1;
        tick(5);
        check("R2 unrouted pin", int'(pending_o), 0);
        check("R2 unrouted req", int'(irq_req_o), 0);
        ext_irq_i[8] = 1'b0;

        // R3/R9: level bit 0 appears after 3 edges, outputs one edge later.
        ext_irq_i[0] = 1'b1;
        tick(2);
        check("R3 not yet", int'(pending_o[0]), 0);
        tick(1);
        check("R3 set", int'(pending_o[0]), 1);
        check("R9 req lags", int'(irq_req_o), 0);
        tick(1);
        check("R9 req", int'(irq_req_o), 1);
        check("R7 level1", int'(irq_level_o), 1);

        // R5: clearing a level bit has no effect.
        clr_we = 1'b1; clr_wdata = 8'h01;
        tick(1);
        clr_we = 1'b0; clr_wdata = '0;
        check("R5 level kept", int'(pending_o[0]), 1);
        ext_irq_i[0] = 1'b0;
        tick(3);
        check("R3 cleared", int'(pending_o[0]), 0);

        // R4: edge bit 1 survives its pin falling.
        ext_irq_i[1] = 1'b1;
        tick(1);
        ext_irq_i[1] = 1'b0;
        tick(5);
        check("R4 edge held", int'(pending_o[1]), 1);

        // R5: a zero clear bit leaves it, a one clears it at the next edge.
        clr_we = 1'b1; clr_wdata = 8'hFD;
        tick(1);
        check("R5 zero bit kept", int'(pending_o[1]), 1);
        clr_wdata = 8'h02;
        tick(1);
        clr_we = 1'b0; clr_wdata = '0;
        check("R5 cleared", int'(pending_o[1]), 0);

        // R5: clear in the same cycle as a new rising edge; the edge wins.
        ext_irq_i[3] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        clr_we = 1'b1; clr_wdata = 8'h08;
        tick(1);
        clr_we = 1'b0; clr_wdata = '0;
        check("R5 set wins", int'(pending_o[3]), 1);
        ext_irq_i[3] = 1'b0;

        // R6/R9: enable removed; request drops one edge after the write.
        tick(1);
        check("R7 level2", int'(irq_level_o), 2);
        en_we = 1'b1; en_wdata = 8'h00;
        tick(1);
        en_we = 1'b0;
        check("R9 still up", int'(irq_req_o), 1);
        tick(1);
        check("R6 masked", int'(irq_req_o), 0);
        check("R8 zero", int'(irq_level_o), 0);

        // Sweep: all pending patterns, all current levels, eight enable masks.
        for (int p = 0; p < 256; p++) begin
            load_pending(p);
            check("R3 R4 pattern", int'(pending_o), p);
            ev = '{8'hFF, 8'h00, 8'h55, 8'hAA, 8'h0F, 8'hF0, p, (~p) & 8'hFF};
            for (int cur = 0; cur < 4; cur++) begin
                for (int j = 0; j < 8; j++) begin
                    write_regs(ev[j], cur);
                    tick(1);
                    check("R7 R10 level", int'(irq_level_o), model(p, ev[j], cur));
                    check("R6 R8 req", int'(irq_req_o), (model(p, ev[j], cur) != 0) ? 1 : 0);
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule